// File: doc/BRIEF.md
# Data-Processing Execute Unit

This block is the execute stage of a small 32-bit processor that handles only register-to-register arithmetic and logic. Each cycle it takes one instruction word and the current status word. It decodes the word as one of sixteen data-processing operations, selects two registers from the register file, and forms the second operand from either a register or a zero-extended 8-bit immediate. It computes the result, then drives the destination select, the write data and the write enable back to the register file. It also returns an updated status word.

The status word carries the condition flags in bits 31:28: N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bit 0 is the illegal-instruction flag. The block is purely combinational. Register reads, the result and the new status all settle within the cycle in which the instruction is presented. Storing the status word and the register file belongs to the surrounding pipeline.

Instruction fields used by the decoder are as follows. Bits 31:26 must be zero. Bit 25 chooses the immediate form. Bits 24:21 hold the operation. Bit 20 requests a flag update. Bits 19:16 name the first source, and bits 15:12 name the destination. In register form, bits 3:0 name the second source and bits 11:4 must be zero. In immediate form, bits 7:0 hold the immediate and bits 11:8 must be zero.

Top module: `dp_exec_unit`

## Requirements
- R1: Logical operations produce their result on the write data, with A the first operand and B the second: code 0 A&B, code 1 A^B, code 12 A|B, code 13 B, code 14 A&~B, code 15 ~B.
- R2: Arithmetic operations produce their result on the write data: code 4 A+B, code 2 A-B, code 3 B-A, code 5 A+B+C, code 6 A-B-(1-C), code 7 B-A-(1-C). C is status bit 29 on the input.
- R3: When an arithmetic or compare operation updates flags, C becomes the unsigned carry out for additions and the inverse of the borrow for subtractions. V becomes 1 exactly when the signed result overflows 32 bits.
- R4: The compare forms never assert the write enable and always update the flags. These are code 8 (test, A&B), code 9 (test-equal, A^B), code 10 (compare, A-B) and code 11 (compare-negative, A+B). A compare form with bit 20 clear is illegal.
- R5: On every flag update, N takes bit 31 of the result and Z is 1 exactly when the result is zero. Logical operations and the two logical compares leave C and V as they were on the input.
- R6: A legal non-compare operation with bit 20 clear asserts the write enable and returns bits 31:28 unchanged.
- R7: The first read select carries bits 19:16 and the destination select carries bits 15:12. In register form the second read select carries bits 3:0. In immediate form the second operand is bits 7:0 zero-extended, and the register value is ignored.
- R8: An instruction is illegal if any of the following holds: a bit in 31:26 is nonzero; in register form, a bit in 11:4 is nonzero; in immediate form, a bit in 11:8 is nonzero; or a move (13 or 15) has a nonzero first-source field. An illegal instruction drives the write enable low, sets status bit 0 and leaves every other status bit unchanged.
- R9: For a legal instruction, status bit 0 is cleared and status bits 27:1 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| status_i | input | 32 | Current status word |
| rs1_sel_o | output | 4 | First register read select |
| rs2_sel_o | output | 4 | Second register read select |
| rs1_data_i | input | DATA_W | First register value |
| rs2_data_i | input | DATA_W | Second register value |
| rd_sel_o | output | 4 | Destination register select |
| wr_data_o | output | DATA_W | Result to write back |
| wr_en_o | output | 1 | Register write enable |
| status_o | output | 32 | Updated status word |

## Verification
The assertions check the following on every evaluation:
- an illegal word never writes and changes only bit 0 of the status word;
- a compare never writes;
- N and Z follow the result whenever flags update;
- logical operations keep C and V;
- a legal word passes bits 27:1 through;
- an instruction without a flag update keeps the flag nibble.

The numeric results, the carry and overflow values, the selection of the carry-in, and the use of the immediate in place of the register value can only be shown by the bench. It sweeps every operation against boundary operand pairs and sweeps every forbidden bit.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;
  localparam int INSTR_W = 32;
  localparam int STAT_W  = 32;
  localparam int SEL_W   = 4;
  localparam int IMM_W   = 8;
  localparam int FLAG_N  = 31;
  localparam int FLAG_Z  = 30;
  localparam int FLAG_C  = 29;
  localparam int FLAG_V  = 28;
  localparam int BAD_BIT = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  typedef struct packed {
    dp_op_e             op;
    logic               use_imm;
    logic               set_flags;
    logic [SEL_W-1:0]   rn;
    logic [SEL_W-1:0]   rd;
    logic [SEL_W-1:0]   rm;
    logic [IMM_W-1:0]   imm;
    logic               is_cmp;
    logic               legal;
  } dp_dec_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dp_dec_t            dec_o
);
  logic hi_ok, op2_ok, cmp_ok, mov_ok;
  dp_op_e op;

  assign op = dp_op_e'(instr_i[24:21]);

  always_comb begin
    dec_o.op        = op;
    dec_o.use_imm   = instr_i[25];
    dec_o.set_flags = instr_i[20];
    dec_o.rn        = instr_i[19:16];
    dec_o.rd        = instr_i[15:12];
    dec_o.rm        = instr_i[3:0];
    dec_o.imm       = instr_i[7:0];
    dec_o.is_cmp    = (instr_i[24:23] == 2'b10);
    dec_o.legal     = hi_ok && op2_ok && cmp_ok && mov_ok;
  end

  // condition field unsupported, class bits must select data processing
  assign hi_ok  = (instr_i[31:26] == '0);
  assign op2_ok = instr_i[25] ? (instr_i[11:8] == '0) : (instr_i[11:4] == '0);
  assign cmp_ok = (instr_i[24:23] != 2'b10) || instr_i[20];
  assign mov_ok = !((op == OP_MOV) || (op == OP_MVN)) || (instr_i[19:16] == '0);
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dp_op_e            op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o,
  output logic              arith_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] x, y;
  logic              ci;
  logic [DATA_W:0]   sum;

  // one adder; subtract forms invert an operand, reverse forms swap
  always_comb begin
    x = a_i;
    y = b_i;
    ci = 1'b0;
    arith_o = 1'b1;
    unique case (op_i)
      OP_SUB, OP_CMP: begin y = ~b_i; ci = 1'b1; end
      OP_RSB:         begin x = b_i; y = ~a_i; ci = 1'b1; end
      OP_ADD, OP_CMN: ci = 1'b0;
      OP_ADC:         ci = cin_i;
      OP_SBC:         begin y = ~b_i; ci = cin_i; end
      OP_RSC:         begin x = b_i; y = ~a_i; ci = cin_i; end
      default:        arith_o = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  assign c_o = sum[DATA_W];
  assign v_o = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = sum[MSB:0];
    endcase
  end
endmodule

// File: rtl/dp_status.sv
module dp_status
  import dp_exec_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  input  logic              legal_i,
  input  logic              upd_i,
  input  logic              arith_i,
  input  logic              n_i,
  input  logic              z_i,
  input  logic              c_i,
  input  logic              v_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o = status_i;
    status_o[BAD_BIT] = !legal_i;
    if (legal_i && upd_i) begin
      status_o[FLAG_N] = n_i;
      status_o[FLAG_Z] = z_i;
      if (arith_i) begin
        status_o[FLAG_C] = c_i;
        status_o[FLAG_V] = v_i;
      end
    end
  end

  always_comb begin
    if (legal_i && upd_i && !arith_i)
      p_logic_keeps_cv_r5: assert (status_o[FLAG_C] == status_i[FLAG_C] &&
                                   status_o[FLAG_V] == status_i[FLAG_V])
        else $error("logic op changed C/V");
    if (legal_i && !upd_i)
      p_noupd_keep_r6: assert (status_o[STAT_W-1:1] == status_i[STAT_W-1:1])
        else $error("status changed without update");
    if (legal_i)
      p_mid_bits_r9: assert (status_o[FLAG_V-1:1] == status_i[FLAG_V-1:1] && !status_o[BAD_BIT])
        else $error("middle status bits disturbed");
  end
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dp_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [SEL_W-1:0]   rs1_sel_o,
  output logic [SEL_W-1:0]   rs2_sel_o,
  input  logic [DATA_W-1:0]  rs1_data_i,
  input  logic [DATA_W-1:0]  rs2_data_i,
  output logic [SEL_W-1:0]   rd_sel_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               wr_en_o,
  output logic [STAT_W-1:0]  status_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  dp_dec_t           dec;
  logic [DATA_W-1:0] op2;
  logic              c_new, v_new, arith, upd;

  dp_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign rs1_sel_o = dec.rn;
  assign rs2_sel_o = dec.rm;
  assign rd_sel_o  = dec.rd;
  assign op2       = dec.use_imm ? {{PAD_W{1'b0}}, dec.imm} : rs2_data_i;

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (dec.op),
    .a_i    (rs1_data_i),
    .b_i    (op2),
    .cin_i  (status_i[FLAG_C]),
    .res_o  (wr_data_o),
    .c_o    (c_new),
    .v_o    (v_new),
    .arith_o(arith)
  );

  assign upd     = dec.set_flags || dec.is_cmp;
  assign wr_en_o = dec.legal && !dec.is_cmp;

  dp_status u_st (
    .status_i(status_i),
    .legal_i (dec.legal),
    .upd_i   (upd),
    .arith_i (arith),
    .n_i     (wr_data_o[DATA_W-1]),
    .z_i     (wr_data_o == '0),
    .c_i     (c_new),
    .v_i     (v_new),
    .status_o(status_o)
  );

  always_comb begin
    if (!dec.legal)
      p_bad_quiet_r8: assert (!wr_en_o && status_o[BAD_BIT] &&
                              status_o[STAT_W-1:1] == status_i[STAT_W-1:1])
        else $error("illegal word had side effects");
    if (dec.is_cmp)
      p_cmp_no_write_r4: assert (!wr_en_o) else $error("compare wrote a register");
    if (dec.legal && upd)
      p_nz_track_r5: assert (status_o[FLAG_N] == wr_data_o[DATA_W-1] &&
                             status_o[FLAG_Z] == (wr_data_o == '0))
        else $error("N/Z do not follow result");
  end
endmodule

// File: tb/sim_dp_exec_unit.sv
module sim_dp_exec_unit;
  logic        clk = 1'b0;
  logic [31:0] instr, status_in, status_out, rs1_data, rs2_data, wr_data;
  logic [3:0]  rs1_sel, rs2_sel, rd_sel;
  logic        wr_en;
  logic [31:0] regs [16];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  assign rs1_data = regs[rs1_sel];
  assign rs2_data = regs[rs2_sel];

  dp_exec_unit u0 (
    .instr_i(instr), .status_i(status_in),
    .rs1_sel_o(rs1_sel), .rs2_sel_o(rs2_sel),
    .rs1_data_i(rs1_data), .rs2_data_i(rs2_data),
    .rd_sel_o(rd_sel), .wr_data_o(wr_data), .wr_en_o(wr_en),
    .status_o(status_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s instr=%h act=%h exp=%h", tag, instr, act, exp);
    end
  endtask

  // returns {N,Z,C,V,result}
  function automatic logic [35:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input logic ci);
    logic [31:0] r;
    logic c, v;
    longint sa, sb, sr;
    logic [32:0] w, lhs, rhs;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    c = 1'b0; sr = 0;
    case (op)
      0, 8:  r = a & b;
      1, 9:  r = a ^ b;
      12:    r = a | b;
      13:    r = b;
      14:    r = a & ~b;
      15:    r = ~b;
      2, 10: begin r = a - b; c = (a >= b); sr = sa - sb; end
      3:     begin r = b - a; c = (b >= a); sr = sb - sa; end
      4, 11: begin w = {1'b0, a} + {1'b0, b}; r = w[31:0]; c = w[32]; sr = sa + sb; end
      5:     begin w = {1'b0, a} + {1'b0, b} + 33'(ci); r = w[31:0]; c = w[32];
                   sr = sa + sb + longint'(ci); end
      6:     begin r = a - b - 32'(!ci); lhs = {1'b0, a}; rhs = {1'b0, b} + 33'(!ci);
                   c = (lhs >= rhs); sr = sa - sb - longint'(!ci); end
      default: begin r = b - a - 32'(!ci); lhs = {1'b0, b}; rhs = {1'b0, a} + 33'(!ci);
                   c = (lhs >= rhs); sr = sb - sa - longint'(!ci); end
    endcase
    v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    return {r[31], r == 32'd0, c, v, r};
  endfunction

  task automatic fill_regs();
    for (int i = 0; i < 16; i++) regs[i] = 32'hC0DE_0000 | 32'(i);
  endtask

  task automatic run_bad(input logic [31:0] w, input string tag);
    @(negedge clk);
    fill_regs();
    instr = w;
    status_in = 32'h9ABC_DEF0;
    #2;
    chk({tag, " wr_en"}, 32'(wr_en), 32'd0);
    chk({tag, " status"}, status_out, 32'h9ABC_DEF1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [8];
    logic [31:0] base;
    vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
             32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001, 32'h0000_00FF};
    fill_regs();
    instr = '0;
    status_in = '0;

    // idle word: AND r0,r0,r0 with no flag update is legal
    @(negedge clk);
    regs[0] = 32'h0;
    #2;
    chk("R9 idle status", status_out, 32'h0);
    chk("R6 idle wr_en", 32'(wr_en), 32'd1);

    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++)
        for (int im = 0; im < 2; im++)
          for (int ci = 0; ci < 2; ci++)
            for (int ia = 0; ia < 8; ia++)
              for (int ib = 0; ib < 8; ib++) begin
                logic cmp, arith, upd;
                logic [3:0] rn, rm, rd;
                logic [31:0] a, b, exp_st;
                logic [35:0] m;
                string dtag, stag;
                cmp = (op >= 8 && op <= 11);
                if (cmp && s == 0) continue;
                arith = (op >= 2 && op <= 7) || op == 10 || op == 11;
                upd = (s == 1) || cmp;
                rn = (op == 13 || op == 15) ? 4'd0 : 4'd2;
                rm = 4'd11;
                rd = 4'(op);
                a = vals[ia];
                b = im ? {24'h0, vals[ib][7:0]} : vals[ib];
                @(negedge clk);
                fill_regs();
                regs[rn] = a;
                if (im == 0) regs[rm] = b;
                else for (int k = 0; k < 16; k++) if (k != int'(rn)) regs[k] = 32'hFFFF_FF00;
                instr = {4'h0, 2'b00, 1'(im), 4'(op), 1'(s), rn, rd,
                         im ? {4'h0, vals[ib][7:0]} : {8'h00, rm}};
                status_in = {ia[0], ib[0], 1'(ci), ia[1], 24'h5A5A5A, 4'b1011};
                #2;
                m = model(op, a, b, 1'(ci));
                exp_st = status_in;
                exp_st[0] = 1'b0;
                if (upd) begin
                  exp_st[31] = m[35];
                  exp_st[30] = m[34];
                  if (arith) begin exp_st[29] = m[33]; exp_st[28] = m[32]; end
                end
                dtag = arith ? "R2 result" : "R1 result";
                if (im) dtag = {dtag, " R7 imm"};
                stag = cmp ? "R4 status" : (s == 0) ? "R6 status" : arith ? "R3 status" : "R5 status";
                if (!cmp) chk(dtag, wr_data, m[31:0]);
                chk(cmp ? "R4 wr_en" : "R6 wr_en", 32'(wr_en), cmp ? 32'd0 : 32'd1);
                chk(stag, status_out, exp_st);
                chk("R9 pass bits", {4'h0, status_out[27:0]}, {4'h0, status_in[27:1], 1'b0});
                chk("R7 selects", {20'h0, rs1_sel, rd_sel, rs2_sel},
                    {20'h0, rn, rd, im ? vals[ib][3:0] : rm});
              end

    base = {4'h0, 2'b00, 1'b0, 4'd4, 1'b1, 4'd2, 4'd1, 12'h003};
    for (int bt = 26; bt < 32; bt++) run_bad(base | (32'd1 << bt), "R8 high bit");
    for (int bt = 4; bt < 12; bt++) run_bad(base | (32'd1 << bt), "R8 reg-form bit");
    base = {4'h0, 2'b00, 1'b1, 4'd4, 1'b1, 4'd2, 4'd1, 12'h03C};
    for (int bt = 8; bt < 12; bt++) run_bad(base | (32'd1 << bt), "R8 imm-form bit");
    for (int r = 1; r < 16; r++) begin
      run_bad({4'h0, 2'b00, 1'b0, 4'd13, 1'b0, 4'(r), 4'd1, 12'h003}, "R8 mov rn");
      run_bad({4'h0, 2'b00, 1'b0, 4'd15, 1'b1, 4'(r), 4'd1, 12'h003}, "R8 mvn rn");
    end
    for (int op = 8; op < 12; op++)
      run_bad({4'h0, 2'b00, 1'b0, 4'(op), 1'b0, 4'd2, 4'd0, 12'h003}, "R4 compare without S");

    // immediate form with bits 7:4 set stays legal
    @(negedge clk);
    fill_regs();
    instr = {4'h0, 2'b00, 1'b1, 4'd13, 1'b0, 4'd0, 4'd6, 12'h0F0};
    status_in = 32'h0000_0001;
    #2;
    chk("R7 imm mov data", wr_data, 32'h0000_00F0);
    chk("R9 legal clears bit0", status_out, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule